// File: doc/BRIEF.md
# Seconds-Resolution System Watchdog

This block is a watchdog peripheral with a small synchronous register port of two 32-bit words. The first word is a control and status register, and the second is a seconds counter. Software writes a timeout in seconds, sets the run bit and then reloads the countdown often enough with a self-clearing trigger bit. If software stops reloading and the countdown reaches zero, the block produces a one-cycle request. That request goes either to the system-reset logic or to an alternative action line, depending on an action-select bit.

A prescaler divides the core clock into one-second ticks. A sticky fired flag records that an expiry took place. This flag is cleared only by a power-on reset or by software, so it survives the system reset that the watchdog itself requests. A strap input disables the timer in hardware, and its state can be read back.

Top module: `wdog_timer`

## Requirements
- R1: After `por`, the control word (offset 0) reads 0, apart from bit 3, which mirrors `hw_disable`. The count word (offset 4) reads 0. The stored timeout is 65535.
- R2: `rst` alone clears the run bit, the action bit, the live count and the timeout (back to 65535), but leaves the fired flag (control bit 1) unchanged.
- R3: A write to offset 4 stores `wdata[15:0]` as the timeout, and a value of 0 is stored as 1. Reading offset 4 returns the live seconds remaining in bits 15:0, with bits 31:16 as 0.
- R4: Writing control bit 0 from 0 to 1 loads the count from the timeout and starts the countdown. The first decrement occurs TICKS_PER_SEC cycles after the write edge, and each later decrement follows after another TICKS_PER_SEC cycles.
- R5: Writing control bit 0 as 0 freezes the count at its present value and keeps the timeout.
- R6: Writing 1 to control bit 7 reloads the count from the timeout and restarts the prescaler. Bit 7 always reads 0. A trigger written while bit 0 is 0 loads the count but does not start the countdown.
- R7: When the count steps from 1 to 0, the block pulses `sys_rst_req` for exactly one cycle if control bit 2 is 0, or pulses `alt_act` for one cycle if bit 2 is 1, and never both. The count then stays at 0 until a trigger or a start.
- R8: Control bit 1 (fired) is set by an expiry and cleared by writing 1 to it. If both happen in the same cycle, the set wins.
- R9: Control bit 3 reads `hw_disable`. While `hw_disable` is high, the count does not change and no expiry happens.
- R10: Only offsets 0 and 4 are decoded. Every other offset reads 0 and ignores writes. Reserved control bits (31:8 and 6:4) read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous system reset, active high; keeps the fired flag |
| por | input | 1 | Synchronous power-on reset, active high; clears everything |
| hw_disable | input | 1 | Hardware strap that blocks the timer |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| sys_rst_req | output | 1 | One-cycle system-reset request on expiry |
| alt_act | output | 1 | One-cycle alternative-action request on expiry |

## Verification
An error in the prescaler phase moves the moment of the next change in the count read at offset 4 by whole cycles. It also shifts the expiry pulse by the same amount, so a cycle-exact comparison of the readback and the two request lines exposes it within one second of ticks. A lost or stuck fired flag, or a wrong action selection, shows up on the next expiry or at the next read of the control word. The bench checks the read data at a random offset and both request lines in every cycle against a behavioural model.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int CTL_RUN   = 0;
    localparam int CTL_FIRED = 1;
    localparam int CTL_ACT   = 2;
    localparam int CTL_DIS   = 3;
    localparam int CTL_TRIG  = 7;

    localparam int          SEC_W   = 16;
    localparam logic [15:0] TMO_MAX = 16'hFFFF;

    typedef enum logic {
        ACT_RESET = 1'b0,
        ACT_ALT   = 1'b1
    } act_e;

    typedef struct packed {
        logic run;
        act_e act;
        logic fired;
    } ctl_t;

    typedef enum logic [1:0] {
        SEL_CTL  = 2'd0,
        SEL_CNT  = 2'd1,
        SEL_NONE = 2'd2
    } sel_e;

    function automatic logic [SEC_W-1:0] clamp_tmo(input logic [SEC_W-1:0] v);
        return (v == '0) ? SEC_W'(1) : v;
    endfunction

    function automatic logic [31:0] pack_ctl(input ctl_t c, input logic dis);
        logic [31:0] w;
        w = '0;
        w[CTL_RUN]   = c.run;
        w[CTL_FIRED] = c.fired;
        w[CTL_ACT]   = c.act;
        w[CTL_DIS]   = dis;
        return w;
    endfunction

endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
    parameter int TICKS = 100_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic run_en,
    input  logic restart,
    output logic tick
);
    localparam int PW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICKS - 1);

    logic [PW-1:0] phase_q;

    assign tick = run_en && (phase_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart || !run_en || tick)
            phase_q <= '0;
        else
            phase_q <= phase_q + 1'b1;
    end

    // R4: ticks are at least TICKS cycles apart
    p_tick_gap_r4: assert property (@(posedge clk) disable iff (rst)
        (tick && TICKS > 1) |=> !tick)
        else $error("tick repeated");

endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [SEC_W-1:0] tmo,
    input  logic             tick,
    input  act_e             act,
    output logic [SEC_W-1:0] cnt,
    output logic             expire,
    output logic             rst_req,
    output logic             alt_req
);
    logic [SEC_W-1:0] cnt_q;

    assign cnt    = cnt_q;
    assign expire = tick && (cnt_q == SEC_W'(1)) && !load && !rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            rst_req <= 1'b0;
            alt_req <= 1'b0;
        end else begin
            rst_req <= expire && (act == ACT_RESET);
            alt_req <= expire && (act == ACT_ALT);
            if (load)
                cnt_q <= tmo;
            else if (tick)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    // R7: without a load the count never grows
    p_no_rise_r7: assert property (@(posedge clk) disable iff (rst)
        !load |=> (cnt_q <= $past(cnt_q)))
        else $error("count rose without load");

    // R7: a request lasts a single cycle
    p_one_cycle_r7: assert property (@(posedge clk) disable iff (rst)
        (rst_req || alt_req) |=> !(rst_req || alt_req))
        else $error("request longer than one cycle");

    // R7: only one request line at a time
    p_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rst_req, alt_req}))
        else $error("both request lines high");

endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              por,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [31:0]       wdata,
    input  logic              hw_dis,
    input  logic              expire,
    input  logic [SEC_W-1:0]  cnt,
    output ctl_t              ctl,
    output logic [SEC_W-1:0]  tmo,
    output logic              load,
    output logic [31:0]       rdata
);
    sel_e sel;
    logic wr_ctl, wr_cnt;
    logic run_q, fired_q;
    act_e act_q;
    logic [SEC_W-1:0] tmo_q;

    always_comb begin
        if (addr == ADDR_W'(0))
            sel = SEL_CTL;
        else if (addr == ADDR_W'(4))
            sel = SEL_CNT;
        else
            sel = SEL_NONE;
    end

    assign wr_ctl = wr && (sel == SEL_CTL);
    assign wr_cnt = wr && (sel == SEL_CNT);
    assign load   = wr_ctl && !rst && (wdata[CTL_TRIG] || (wdata[CTL_RUN] && !run_q));

    always_ff @(posedge clk) begin
        if (por || rst) begin
            run_q <= 1'b0;
            act_q <= ACT_RESET;
            tmo_q <= TMO_MAX;
        end else begin
            if (wr_ctl) begin
                run_q <= wdata[CTL_RUN];
                act_q <= act_e'(wdata[CTL_ACT]);
            end
            if (wr_cnt)
                tmo_q <= clamp_tmo(wdata[SEC_W-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (por)
            fired_q <= 1'b0;
        else if (expire)
            fired_q <= 1'b1;
        else if (wr_ctl && !rst && wdata[CTL_FIRED])
            fired_q <= 1'b0;
    end

    assign ctl.run   = run_q;
    assign ctl.act   = act_q;
    assign ctl.fired = fired_q;
    assign tmo       = tmo_q;

    always_comb begin
        case (sel)
            SEL_CTL: rdata = pack_ctl(ctl, hw_dis);
            SEL_CNT: rdata = {{(32-SEC_W){1'b0}}, cnt};
            default: rdata = '0;
        endcase
    end

    // R8: expiry sets the flag
    p_fired_set_r8: assert property (@(posedge clk) disable iff (por)
        expire |=> fired_q)
        else $error("fired not set");

    // R8: write-one clears the flag when no expiry competes
    p_fired_clear_r8: assert property (@(posedge clk) disable iff (por)
        (wr_ctl && !rst && wdata[CTL_FIRED] && !expire) |=> !fired_q)
        else $error("fired not cleared");

    // R2: system reset keeps the flag
    p_fired_keep_r2: assert property (@(posedge clk) disable iff (por)
        (rst && fired_q) |=> fired_q)
        else $error("fired lost on system reset");

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int TICKS_PER_SEC = 100_000_000,
    parameter int ADDR_W        = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              por,
    input  logic              hw_disable,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              sys_rst_req,
    output logic              alt_act
);
    logic             srst;
    ctl_t             ctl;
    logic [SEC_W-1:0] tmo;
    logic [SEC_W-1:0] cnt;
    logic             load, tick, expire, run_en;

    assign srst   = rst || por;
    assign run_en = ctl.run && !hw_disable && (cnt != '0);

    wdog_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .por    (por),
        .addr   (bus_addr),
        .wr     (bus_wr),
        .wdata  (bus_wdata),
        .hw_dis (hw_disable),
        .expire (expire),
        .cnt    (cnt),
        .ctl    (ctl),
        .tmo    (tmo),
        .load   (load),
        .rdata  (bus_rdata)
    );

    wdog_prescale #(.TICKS(TICKS_PER_SEC)) u_pre (
        .clk     (clk),
        .rst     (srst),
        .run_en  (run_en),
        .restart (load),
        .tick    (tick)
    );

    wdog_countdown u_cd (
        .clk     (clk),
        .rst     (srst),
        .load    (load),
        .tmo     (tmo),
        .tick    (tick),
        .act     (ctl.act),
        .cnt     (cnt),
        .expire  (expire),
        .rst_req (sys_rst_req),
        .alt_req (alt_act)
    );

    // R9: the strap blocks any expiry request
    p_no_fire_off_r9: assert property (@(posedge clk) disable iff (srst)
        hw_disable |=> !(sys_rst_req || alt_act))
        else $error("request while disabled");

    // R9: the strap freezes the count unless software loads it
    p_frozen_off_r9: assert property (@(posedge clk) disable iff (srst)
        (hw_disable && !load) |=> $stable(cnt))
        else $error("count moved while disabled");

endmodule

// File: tb/wdog_timer_bench.sv
`timescale 1ns/1ps
module wdog_timer_bench;
    localparam int TK = 4;

    logic        clk = 1'b0;
    logic        rst, por, hw_dis, wr;
    logic [2:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        req, alt;

    int n_chk = 0;
    int n_fail = 0;
    bit chk_en = 0;

    always #2.5 clk = ~clk;

    wdog_timer #(.TICKS_PER_SEC(TK), .ADDR_W(3)) u_wdog_timer (
        .clk(clk), .rst(rst), .por(por), .hw_disable(hw_dis),
        .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
        .bus_rdata(rdata), .sys_rst_req(req), .alt_act(alt)
    );

    // behavioural model of the requirements
    bit          m_run, m_act, m_fired, m_req, m_alt;
    logic [15:0] m_tmo, m_cnt;
    int          m_ph;
    bit          e_en, e_tk, e_ld, e_wc, e_wn;

    always @(posedge clk) begin
        if (por) begin
            m_run = 0; m_act = 0; m_fired = 0; m_tmo = 16'hFFFF;
            m_cnt = 0; m_ph = 0; m_req = 0; m_alt = 0;
        end else if (rst) begin
            m_run = 0; m_act = 0; m_tmo = 16'hFFFF;
            m_cnt = 0; m_ph = 0; m_req = 0; m_alt = 0;
        end else begin
            e_en = m_run && !hw_dis && (m_cnt != 0);
            e_tk = e_en && (m_ph == TK - 1);
            e_wc = wr && (addr == 3'd0);
            e_wn = wr && (addr == 3'd4);
            e_ld = e_wc && (wdata[7] || (wdata[0] && !m_run));
            m_req = 0; m_alt = 0;
            if (e_wc && wdata[1]) m_fired = 0;
            if (e_ld) begin
                m_cnt = m_tmo; m_ph = 0;
            end else if (e_tk) begin
                if (m_cnt == 1) begin
                    m_fired = 1;
                    if (m_act) m_alt = 1; else m_req = 1;
                end
                m_cnt = m_cnt - 1; m_ph = 0;
            end else begin
                m_ph = e_en ? m_ph + 1 : 0;
            end
            if (e_wc) begin m_run = wdata[0]; m_act = wdata[2]; end
            if (e_wn) m_tmo = (wdata[15:0] == 0) ? 16'd1 : wdata[15:0];
        end
    end

    function automatic logic [31:0] model_read(input logic [2:0] a);
        if (a == 3'd0) return {28'd0, hw_dis, m_act, m_fired, m_run};
        if (a == 3'd4) return {16'd0, m_cnt};
        return 32'd0;
    endfunction

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // cycle-by-cycle comparison, away from the edge
    always @(posedge clk) begin
        #1;
        if (chk_en) begin
            chk(rdata, model_read(addr), "R3 R5 R6 R8 R9 R10 readback");
            chk({31'd0, req}, {31'd0, m_req}, "R7 sys_rst_req");
            chk({31'd0, alt}, {31'd0, m_alt}, "R7 alt_act");
        end
    end

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1;
        @(negedge clk);
        wr = 0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
        addr = a;
        #0.5;
        chk(rdata, exp, tag);
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        por = 1; rst = 0; hw_dis = 0; wr = 0; addr = 0; wdata = 0;
        void'($urandom(32'd2024));
        @(negedge clk);
        chk_en = 1;
        repeat (2) @(negedge clk);
        por = 0;
        @(negedge clk);
        rd_chk(3'd0, 32'h0, "R1 control after por");
        rd_chk(3'd4, 32'h0, "R1 count after por");

        wr_reg(3'd4, 32'd3);
        wr_reg(3'd0, 32'h1);
        rd_chk(3'd4, 32'd3, "R4 loaded on start");
        repeat (3) @(negedge clk);
        rd_chk(3'd4, 32'd3, "R4 no early decrement");
        @(negedge clk);
        rd_chk(3'd4, 32'd2, "R4 first decrement");
        repeat (8) @(negedge clk);
        chk({31'd0, req}, 32'd1, "R7 reset request");
        chk({31'd0, alt}, 32'd0, "R7 no alt request");
        rd_chk(3'd4, 32'd0, "R7 count at zero");
        rd_chk(3'd0, 32'h3, "R8 fired set");
        @(negedge clk);
        chk({31'd0, req}, 32'd0, "R7 single cycle");
        repeat (6) @(negedge clk);
        rd_chk(3'd4, 32'd0, "R7 held at zero");

        rst = 1;
        @(negedge clk);
        rst = 0;
        rd_chk(3'd0, 32'h2, "R2 fired survives rst");
        rd_chk(3'd4, 32'h0, "R2 count cleared");
        wr_reg(3'd0, 32'h2);
        rd_chk(3'd0, 32'h0, "R8 write-one clear");

        hw_dis = 1;
        wr_reg(3'd4, 32'd2);
        wr_reg(3'd0, 32'h81);
        repeat (20) @(negedge clk);
        rd_chk(3'd4, 32'd2, "R9 frozen while disabled");
        rd_chk(3'd0, 32'h9, "R9 disabled bit");
        hw_dis = 0;
        wr_reg(3'd0, 32'h85);
        rd_chk(3'd4, 32'd2, "R6 trigger reload");
        repeat (8) @(negedge clk);
        chk({31'd0, alt}, 32'd1, "R7 alt request");
        chk({31'd0, req}, 32'd0, "R7 no reset request");

        wr_reg(3'd0, 32'h0);
        wr_reg(3'd4, 32'd5);
        wr_reg(3'd0, 32'h80);
        rd_chk(3'd4, 32'd5, "R6 trigger while stopped loads");
        repeat (10) @(negedge clk);
        rd_chk(3'd4, 32'd5, "R6 trigger does not start");
        rd_chk(3'd0, 32'h2, "R6 trigger reads zero");

        wr_reg(3'd4, 32'd7);
        wr_reg(3'd0, 32'h1);
        repeat (3) @(negedge clk);
        wr_reg(3'd0, 32'h0);
        repeat (12) @(negedge clk);
        rd_chk(3'd4, 32'd6, "R5 frozen after stop");

        wr_reg(3'd4, 32'h0);
        wr_reg(3'd0, 32'h1);
        rd_chk(3'd4, 32'd1, "R3 zero stored as one");
        wr_reg(3'd5, 32'hFFFF_FFFF);
        rd_chk(3'd5, 32'd0, "R10 undecoded offset");
        rd_chk(3'd0, 32'h3, "R10 reserved bits zero");

        for (int i = 0; i < 4000; i++) begin
            int r;
            @(negedge clk);
            wr = 0; rst = 0; por = 0;
            addr = 3'($urandom % 8);
            r = $urandom % 100;
            if (r < 8) begin
                addr = 3'd4; wr = 1; wdata = $urandom % 6;
            end else if (r < 20) begin
                addr = 3'd0; wr = 1; wdata = $urandom;
                wdata[0] = ($urandom % 5) != 0;
                wdata[1] = ($urandom % 4) == 0;
                wdata[7] = ($urandom % 4) == 0;
            end else if (r < 22) begin
                rst = 1;
            end else if (r < 23) begin
                por = 1;
            end else if (r < 26) begin
                hw_dis = ~hw_dis;
            end else if (r < 30) begin
                addr = 3'($urandom % 8);
                if (addr == 3'd0 || addr == 3'd4) addr = 3'd6;
                wr = 1; wdata = $urandom;
            end
        end
        @(negedge clk);
        wr = 0;
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule